// File: doc/BRIEF.md
# Burst Window Register Redirector

This block sits on a peripheral's word-addressed register bus. It lets a DMA engine reach a run of consecutive registers through one fixed window address. A burst configuration word holds two things: a base offset, counted in registers from the first register of the file, and a burst length. Every read or write that lands on the window address is steered to register `base + index`. A hardware index then moves forward by one.

Once the access at the last index of the burst has completed, the index returns to zero. Endless repeated bursts therefore need no software action. Ordinary register addresses decode straight to the register file. The register file is held inside the block as a plain array of 16-bit words, one per 4-byte slot.

Top module: `dma_burst_window`

## Requirements
- R1: After reset, the configuration word reads 0x0000, every register of the file reads 0x0000, and the burst index is 0.
- R2: The configuration word keeps the burst length in bits 12:8 and the base offset in bits 4:0. Bits 15:13 and 7:5 always read as zero.
- R3: A burst length written above 17 is stored and read back as 17, so a burst never exceeds 18 transfers.
- R4: An access to the window address (word 19, byte offset 0x4C) reads or writes the register file word `base + index`.
- R5: The index rises by one after each window access. After the access whose index equals the burst length, it returns to 0. The burst length field holds the transfer count minus one.
- R6: Writing the configuration word (word 18, byte offset 0x48) returns the index to 0 and abandons any burst in progress.
- R7: A window access whose target word is at or beyond the register count reads 0x0000 and changes no storage, yet still advances the index.
- R8: Direct reads and writes of ordinary register addresses leave the index unchanged.
- R9: Direct accesses to words 0 to 17 read and write those registers, and the bus address is a word number (byte offset divided by 4).
- R10: With burst length 0, every window access hits the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe, one access per cycle in which it is high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read strobe, 0 otherwise |

## Verification
The checker assumes the bus issues at most one access per cycle, and that a strobe held high over a clock edge counts as exactly one access. It also assumes no access is made until the internal reset release has completed. The bench drives every access for a single cycle and returns the strobe low in between. It waits several cycles after reset before its first access. Bursts are built from 16-bit register contents that the bench itself wrote, so every redirected value is known ahead of time.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  localparam int DATA_W   = 16;
  localparam int LEN_W    = 5;
  localparam int BASE_W   = 5;
  localparam int ADDR_W   = 5;
  localparam int TGT_W    = 6;
  localparam int MAX_LEN  = 17;
  localparam int LEN_LSB  = 8;
  localparam int BASE_LSB = 0;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [BASE_W-1:0] base;
  } burst_cfg_t;
endpackage

// File: rtl/dbw_rst_sync.sv
module dbw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/dbw_cfg_reg.sv
module dbw_cfg_reg
  import dbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output burst_cfg_t        cfg_q
);
  burst_cfg_t       cfg_d;
  logic [LEN_W-1:0] len_in;

  always_comb begin
    len_in = wdata[LEN_LSB +: LEN_W];
    cfg_d  = cfg_q;
    if (wr_en) begin
      cfg_d.base = wdata[BASE_LSB +: BASE_W];
      cfg_d.len  = (int'(len_in) > MAX_LEN) ? LEN_W'(MAX_LEN) : len_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/dbw_index.sv
module dbw_index
  import dbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] idx_q
);
  logic [LEN_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clear)     idx_d = '0;
    else if (step) idx_d = (idx_q >= len) ? '0 : idx_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/dbw_reg_array.sv
module dbw_reg_array
  import dbw_pkg::*;
#(
  parameter int NUM_REGS = 18,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_en;
    assign word_en = we && (addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= wdata;
    end
    assign mem[g] = word_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == IDX_W'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/dma_burst_window.sv
module dma_burst_window
  import dbw_pkg::*;
#(
  parameter int NUM_REGS = 18,
  parameter int CFG_WORD = 18,
  parameter int WIN_WORD = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [4:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic              rst_n_s;
  burst_cfg_t        cfg_q;
  logic [LEN_W-1:0]  idx_q;
  logic              cfg_hit, win_hit, direct_hit;
  logic [TGT_W-1:0]  tgt;
  logic              tgt_ok;
  logic              arr_sel, arr_we;
  logic [IDX_W-1:0]  arr_addr;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] cfg_rd;

  dbw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign cfg_hit    = bus_valid && (bus_addr == ADDR_W'(CFG_WORD));
  assign win_hit    = bus_valid && (bus_addr == ADDR_W'(WIN_WORD));
  assign direct_hit = bus_valid && (int'(bus_addr) < NUM_REGS);

  assign tgt    = TGT_W'(cfg_q.base) + TGT_W'(idx_q);
  assign tgt_ok = int'(tgt) < NUM_REGS;

  assign arr_sel  = win_hit ? tgt_ok : direct_hit;
  assign arr_addr = win_hit ? IDX_W'(tgt) : IDX_W'(bus_addr);
  assign arr_we   = arr_sel && bus_write;

  dbw_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(cfg_hit && bus_write), .wdata(bus_wdata),
    .cfg_q(cfg_q)
  );

  dbw_index u_idx (
    .clk(clk), .rst_n(rst_n_s),
    .clear(cfg_hit && bus_write), .step(win_hit),
    .len(cfg_q.len), .idx_q(idx_q)
  );

  dbw_reg_array #(.NUM_REGS(NUM_REGS)) u_arr (
    .clk(clk), .rst_n(rst_n_s),
    .we(arr_we), .addr(arr_addr), .wdata(bus_wdata),
    .rdata(arr_rdata)
  );

  always_comb begin
    cfg_rd = '0;
    cfg_rd[LEN_LSB  +: LEN_W]  = cfg_q.len;
    cfg_rd[BASE_LSB +: BASE_W] = cfg_q.base;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (cfg_hit)      bus_rdata = cfg_rd;
      else if (arr_sel) bus_rdata = arr_rdata;
    end
  end
endmodule

// File: rtl/dbw_checker.sv
module dbw_checker
  import dbw_pkg::*;
#(
  parameter int NUM_REGS = 18,
  parameter int CFG_WORD = 18,
  parameter int WIN_WORD = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [4:0]        bus_addr,
  input logic [15:0]       bus_rdata,
  input logic [LEN_W-1:0]  idx,
  input logic [LEN_W-1:0]  len,
  input logic [BASE_W-1:0] base
);
  logic cfg_wr, cfg_rd, win_acc, oor;
  assign cfg_wr  = bus_valid && bus_write && (int'(bus_addr) == CFG_WORD);
  assign cfg_rd  = bus_valid && !bus_write && (int'(bus_addr) == CFG_WORD);
  assign win_acc = bus_valid && (int'(bus_addr) == WIN_WORD);
  assign oor     = (int'(base) + int'(idx)) >= NUM_REGS;

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len) <= MAX_LEN); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |-> (bus_rdata[15:13] == 3'b0 && bus_rdata[7:5] == 3'b0)); // R2
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= len || $past(cfg_wr)); // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && idx < len) |=> idx == $past(idx) + 1'b1); // R5
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && idx == len) |=> idx == '0); // R5
  AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> idx == '0); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_acc && !cfg_wr) |=> $stable(idx)); // R8
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !bus_write && oor) |-> bus_rdata == '0); // R7
endmodule

bind dma_burst_window dbw_checker #(
  .NUM_REGS(NUM_REGS), .CFG_WORD(CFG_WORD), .WIN_WORD(WIN_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n_s),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata),
  .idx(idx_q), .len(cfg_q.len), .base(cfg_q.base)
);

// File: tb/tb_dma_burst_window.sv
module tb_dma_burst_window;
  localparam logic [4:0] CFG = 5'd18;
  localparam logic [4:0] WIN = 5'd19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_burst_window dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(CFG, v);  check("R1 cfg", v, 16'h0000);
    rd(5'd3, v); check("R1 reg3", v, 16'h0000);
    rd(WIN, v);  check("R1 window", v, 16'h0000);
  endtask

  task automatic t_direct();
    logic [15:0] v;
    for (int k = 0; k < 18; k++) wr(5'(k), 16'hA000 + 16'(k));
    for (int k = 0; k < 18; k++) begin
      rd(5'(k), v); check("R9 direct", v, 16'hA000 + 16'(k));
    end
  endtask

  task automatic t_cfg_fields();
    logic [15:0] v;
    wr(CFG, 16'h0A03); rd(CFG, v); check("R2 fields", v, 16'h0A03);
    wr(CFG, 16'hFFFF); rd(CFG, v); check("R3 clamp", v, 16'h111F);
    wr(CFG, 16'h12E0); rd(CFG, v); check("R3 len18", v, 16'h1100);
  endtask

  task automatic t_burst_write();
    logic [15:0] v;
    wr(CFG, 16'h0302);
    for (int i = 0; i < 4; i++) wr(WIN, 16'hB000 + 16'(i));
    wr(WIN, 16'hC000);
    rd(5'd2, v); check("R5 wrap write", v, 16'hC000);
    for (int i = 1; i < 4; i++) begin
      rd(5'(2 + i), v); check("R4 burst write", v, 16'hB000 + 16'(i));
    end
    rd(5'd6, v); check("R4 neighbour", v, 16'hA006);
  endtask

  task automatic t_burst_read();
    logic [15:0] v;
    wr(CFG, 16'h0104);
    rd(WIN, v); check("R4 read i0", v, 16'hB002);
    rd(WIN, v); check("R4 read i1", v, 16'hB003);
    rd(WIN, v); check("R5 read wrap", v, 16'hB002);
  endtask

  task automatic t_cfg_restart();
    logic [15:0] v;
    wr(CFG, 16'h0500);
    rd(WIN, v); check("R6 pre i0", v, 16'hA000);
    rd(WIN, v); check("R6 pre i1", v, 16'hA001);
    wr(CFG, 16'h0500);
    rd(WIN, v); check("R6 restart", v, 16'hA000);
  endtask

  task automatic t_direct_keeps_idx();
    logic [15:0] v;
    wr(CFG, 16'h0206);
    rd(WIN, v); check("R8 i0", v, 16'hA006);
    rd(5'd10, v);
    wr(5'd11, 16'h1234);
    rd(CFG, v);
    rd(WIN, v); check("R8 after direct", v, 16'hA007);
    rd(5'd11, v); check("R9 rewrite", v, 16'h1234);
  endtask

  task automatic t_out_of_range();
    logic [15:0] v;
    wr(CFG, 16'h0310);
    for (int i = 0; i < 4; i++) wr(WIN, 16'hEEEE);
    rd(CFG, v); check("R7 cfg untouched", v, 16'h0310);
    rd(WIN, v); check("R7 in16", v, 16'hEEEE);
    rd(WIN, v); check("R7 in17", v, 16'hEEEE);
    rd(WIN, v); check("R7 oor18", v, 16'h0000);
    rd(WIN, v); check("R7 oor19", v, 16'h0000);
    rd(WIN, v); check("R7 advance wrap", v, 16'hEEEE);
  endtask

  task automatic t_single();
    logic [15:0] v;
    wr(CFG, 16'h0009);
    for (int i = 0; i < 3; i++) begin
      rd(WIN, v); check("R10 len0", v, 16'hA009);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direct();
    t_cfg_fields();
    t_burst_write();
    t_burst_read();
    t_cfg_restart();
    t_direct_keeps_idx();
    t_out_of_range();
    t_single();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule